// File: doc/BRIEF.md
# Sample Offset and Gain Trim Path

This block corrects raw signed converter samples with a stored offset and a stored gain before they leave the converter core. Each accepted sample has the offset subtracted from it first. The difference is then scaled by an unsigned fixed-point gain. The product is rounded to the nearest output LSB and clamped to the signed 24-bit range. The corrected value leaves in the upper bits of a 32-bit word, together with a flag that marks a clamped result.

Both trim values are held in two 32-bit registers behind a small write/read port. The offset is a two's-complement word whose meaningful bits line up with the MSB of the sample, and its low byte always reads as zero. The gain has 6 integer and 24 fraction bits, and writes above 40.0 are limited to 40.0. The pipeline has no stall path. It takes one sample per clock and returns one result per sample, in order, after a fixed latency.

Top module: `sample_trim_path`

## Requirements
- R1: After reset the offset register reads 0x00000000, the gain register reads 0x01000000 (1.0), and out_valid is low.
- R2: A write with reg_addr = 0 stores reg_wdata[31:8] as the offset. The offset read value always has bits 7:0 equal to zero, whatever was written there.
- R3: A write with reg_addr = 1 ignores reg_wdata[31:30]. If reg_wdata[29:0] is at most 0x28000000 (40.0), it is stored as the gain; otherwise the gain becomes 0x28000000. The gain read value has bits 31:30 zero.
- R4: For each sample s (24-bit two's complement) with offset field o (offset bits 31:8) and gain g (bits 29:0, 24 fraction bits), the result is floor(((s - o) * g + 2^23) / 2^24). This rounds to nearest, with halves going toward +infinity. The result is placed in out_word[31:8], and out_word[7:0] is zero.
- R5: A result above 8388607 is output as 0x7FFFFF, and a result below -8388608 is output as 0x800000. out_ovf is 1 exactly for these clamped results and 0 otherwise.
- R6: A sample taken on the rising edge where in_valid is high produces out_valid high right after the second rising edge that follows. Samples on consecutive edges give results on consecutive cycles, in the same order, one result per sample.
- R7: Each sample uses the offset and gain held before its accepting edge. A register write on that same edge affects only later samples.
- R8: reg_rdata shows, without a clock delay, the offset register when reg_addr is 0 and the gain register when reg_addr is 1.
- R9: While in_valid is low, in_sample has no effect, and no result is produced once earlier samples have left the pipeline.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 1 | Register select: 0 offset, 1 gain |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Contents of the selected register |
| in_valid | input | 1 | Sample present on in_sample |
| in_sample | input | 24 | Raw signed sample |
| out_valid | output | 1 | Corrected result present |
| out_word | output | 32 | Corrected result in bits 31:8, zero below |
| out_ovf | output | 1 | Result was clamped to a signed 24-bit limit |

## Verification
The bench builds the block with its default parameters: 24-bit samples, 32-bit words, a 6.24 gain format and a ceiling of 40. With these values, a gain of 1.5 makes exact half-LSB ties for odd differences, so the rounding direction can be checked for both signs. At the 40.0 ceiling, samples of a few hundred thousand codes are enough to drive the output into both saturation limits. A gain of 2^-24 reaches the smallest step of the gain field. Samples at both ends of the 24-bit range, with a nonzero offset, also push the difference one code past the signed limit.

// File: rtl/trim_pkg.sv
package trim_pkg;

  localparam int TRIM_SAMPLE_W   = 24;
  localparam int TRIM_WORD_W     = 32;
  localparam int TRIM_GAIN_INT_W = 6;
  localparam int TRIM_GAIN_FRAC  = 24;
  localparam int TRIM_GAIN_CEIL  = 40;

  typedef enum logic {
    TRIM_SEL_OFFSET = 1'b0,
    TRIM_SEL_GAIN   = 1'b1
  } trim_sel_e;

endpackage

// File: rtl/trim_regs.sv
module trim_regs
  import trim_pkg::*;
#(
  parameter int SAMPLE_W    = TRIM_SAMPLE_W,
  parameter int WORD_W      = TRIM_WORD_W,
  parameter int GAIN_W      = TRIM_GAIN_INT_W + TRIM_GAIN_FRAC,
  parameter int GAIN_FRAC_W = TRIM_GAIN_FRAC,
  parameter int GAIN_CEIL   = TRIM_GAIN_CEIL
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                reg_we,
  input  trim_sel_e           reg_sel,
  input  logic [WORD_W-1:0]   reg_wdata,
  output logic [WORD_W-1:0]   reg_rdata,
  output logic [SAMPLE_W-1:0] off_hi,
  output logic [GAIN_W-1:0]   gain_q,
  output logic                gain_clamp_hit
);

  localparam int PAD_W  = WORD_W - SAMPLE_W;
  localparam int GTOP_W = WORD_W - GAIN_W;
  localparam logic [GAIN_W-1:0] GAIN_ONE   = GAIN_W'(1) << GAIN_FRAC_W;
  localparam logic [GAIN_W-1:0] GAIN_LIMIT = GAIN_W'(GAIN_CEIL) << GAIN_FRAC_W;

  function automatic logic [GAIN_W-1:0] limit_gain(input logic [GAIN_W-1:0] g);
    if (g > GAIN_LIMIT) return GAIN_LIMIT;
    return g;
  endfunction

  logic wr_off;
  logic wr_gain;
  logic [GAIN_W-1:0] gain_field;
  logic unused_dropped_bits;

  assign wr_off     = reg_we && (reg_sel == TRIM_SEL_OFFSET);
  assign wr_gain    = reg_we && (reg_sel == TRIM_SEL_GAIN);
  assign gain_field = reg_wdata[GAIN_W-1:0];
  assign gain_clamp_hit = wr_gain && (gain_field > GAIN_LIMIT);
  assign unused_dropped_bits = ^{reg_wdata[PAD_W-1:0], reg_wdata[WORD_W-1:GAIN_W]};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      off_hi <= '0;
      gain_q <= GAIN_ONE;
    end else begin
      if (wr_off)  off_hi <= reg_wdata[WORD_W-1:PAD_W];
      if (wr_gain) gain_q <= limit_gain(gain_field);
    end
  end

  always_comb begin
    if (reg_sel == TRIM_SEL_GAIN) reg_rdata = {{GTOP_W{1'b0}}, gain_q};
    else                          reg_rdata = {off_hi, {PAD_W{1'b0}}};
  end

endmodule

// File: rtl/trim_pipe.sv
module trim_pipe
  import trim_pkg::*;
#(
  parameter int SAMPLE_W    = TRIM_SAMPLE_W,
  parameter int WORD_W      = TRIM_WORD_W,
  parameter int GAIN_W      = TRIM_GAIN_INT_W + TRIM_GAIN_FRAC,
  parameter int GAIN_FRAC_W = TRIM_GAIN_FRAC
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                in_valid,
  input  logic [SAMPLE_W-1:0] in_sample,
  input  logic [SAMPLE_W-1:0] off_hi,
  input  logic [GAIN_W-1:0]   gain_q,
  output logic                s1_valid,
  output logic                s2_valid,
  output logic                sat_event,
  output logic                out_valid,
  output logic [WORD_W-1:0]   out_word,
  output logic                out_ovf
);

  localparam int DIFF_W = SAMPLE_W + 1;
  localparam int PROD_W = DIFF_W + GAIN_W + 1;
  localparam int PAD_W  = WORD_W - SAMPLE_W;
  localparam logic signed [PROD_W-1:0] HALF_LSB = PROD_W'(1) <<< (GAIN_FRAC_W - 1);
  localparam logic signed [PROD_W-1:0] SAT_MAX  = (PROD_W'(1) <<< (SAMPLE_W - 1)) - PROD_W'(1);
  localparam logic signed [PROD_W-1:0] SAT_MIN  = -(PROD_W'(1) <<< (SAMPLE_W - 1));

  // Stage-one arithmetic: offset removal at full sample precision plus a guard bit
  function automatic logic signed [DIFF_W-1:0] trim_sub(
    input logic signed [SAMPLE_W-1:0] s,
    input logic signed [SAMPLE_W-1:0] o
  );
    return DIFF_W'(s) - DIFF_W'(o);
  endfunction

  // Stage-two arithmetic: signed difference times unsigned fixed-point gain
  function automatic logic signed [PROD_W-1:0] trim_mul(
    input logic signed [DIFF_W-1:0] d,
    input logic [GAIN_W-1:0]        g
  );
    return PROD_W'(d) * $signed(PROD_W'(g));
  endfunction

  // Stage-three arithmetic: round half up at the output LSB, then clamp
  function automatic logic [SAMPLE_W:0] trim_round_sat(input logic signed [PROD_W-1:0] p);
    logic signed [PROD_W-1:0] r;
    r = (p + HALF_LSB) >>> GAIN_FRAC_W;
    if (r > SAT_MAX) return {1'b1, SAT_MAX[SAMPLE_W-1:0]};
    if (r < SAT_MIN) return {1'b1, SAT_MIN[SAMPLE_W-1:0]};
    return {1'b0, r[SAMPLE_W-1:0]};
  endfunction

  logic signed [DIFF_W-1:0] s1_diff;
  logic [GAIN_W-1:0]        s1_gain;
  logic signed [PROD_W-1:0] s2_prod;
  logic [SAMPLE_W:0]        s3_next;

  assign s3_next   = trim_round_sat(s2_prod);
  assign sat_event = s2_valid && s3_next[SAMPLE_W];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1_valid  <= 1'b0;
      s1_diff   <= '0;
      s1_gain   <= '0;
      s2_valid  <= 1'b0;
      s2_prod   <= '0;
      out_valid <= 1'b0;
      out_word  <= '0;
      out_ovf   <= 1'b0;
    end else begin
      s1_valid <= in_valid;
      if (in_valid) begin
        s1_diff <= trim_sub(in_sample, off_hi);
        s1_gain <= gain_q;
      end
      s2_valid <= s1_valid;
      if (s1_valid) s2_prod <= trim_mul(s1_diff, s1_gain);
      out_valid <= s2_valid;
      if (s2_valid) begin
        out_word <= {s3_next[SAMPLE_W-1:0], {PAD_W{1'b0}}};
        out_ovf  <= s3_next[SAMPLE_W];
      end else begin
        out_ovf  <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/sample_trim_path.sv
module sample_trim_path
  import trim_pkg::*;
#(
  parameter int SAMPLE_W    = TRIM_SAMPLE_W,
  parameter int WORD_W      = TRIM_WORD_W,
  parameter int GAIN_INT_W  = TRIM_GAIN_INT_W,
  parameter int GAIN_FRAC_W = TRIM_GAIN_FRAC,
  parameter int GAIN_CEIL   = TRIM_GAIN_CEIL
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                reg_we,
  input  logic                reg_addr,
  input  logic [WORD_W-1:0]   reg_wdata,
  output logic [WORD_W-1:0]   reg_rdata,
  input  logic                in_valid,
  input  logic [SAMPLE_W-1:0] in_sample,
  output logic                out_valid,
  output logic [WORD_W-1:0]   out_word,
  output logic                out_ovf
);

  localparam int GAIN_W = GAIN_INT_W + GAIN_FRAC_W;

  logic [SAMPLE_W-1:0] off_hi;
  logic [GAIN_W-1:0]   gain_q;
  logic                gain_clamp_hit;
  logic                s1_valid;
  logic                s2_valid;
  logic                sat_event;
  trim_sel_e           reg_sel;

  assign reg_sel = trim_sel_e'(reg_addr);

  trim_regs #(
    .SAMPLE_W(SAMPLE_W), .WORD_W(WORD_W), .GAIN_W(GAIN_W),
    .GAIN_FRAC_W(GAIN_FRAC_W), .GAIN_CEIL(GAIN_CEIL)
  ) u_regs (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .off_hi(off_hi), .gain_q(gain_q), .gain_clamp_hit(gain_clamp_hit)
  );

  trim_pipe #(
    .SAMPLE_W(SAMPLE_W), .WORD_W(WORD_W), .GAIN_W(GAIN_W), .GAIN_FRAC_W(GAIN_FRAC_W)
  ) u_pipe (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sample(in_sample),
    .off_hi(off_hi), .gain_q(gain_q),
    .s1_valid(s1_valid), .s2_valid(s2_valid), .sat_event(sat_event),
    .out_valid(out_valid), .out_word(out_word), .out_ovf(out_ovf)
  );

endmodule

// File: rtl/trim_checks.sv
module trim_checks #(
  parameter int SAMPLE_W    = 24,
  parameter int WORD_W      = 32,
  parameter int GAIN_W      = 30,
  parameter int GAIN_FRAC_W = 24,
  parameter int GAIN_CEIL   = 40
) (
  input logic                clk,
  input logic                rst_n,
  input logic                reg_we,
  input logic                reg_addr,
  input logic [WORD_W-1:0]   reg_wdata,
  input logic                in_valid,
  input logic                s1_valid,
  input logic                s2_valid,
  input logic                sat_event,
  input logic                gain_clamp_hit,
  input logic                out_valid,
  input logic [WORD_W-1:0]   out_word,
  input logic                out_ovf,
  input logic [SAMPLE_W-1:0] off_hi,
  input logic [GAIN_W-1:0]   gain_q
);

  localparam int PAD_W = WORD_W - SAMPLE_W;
  localparam logic [GAIN_W-1:0]   GAIN_LIMIT = GAIN_W'(GAIN_CEIL) << GAIN_FRAC_W;
  localparam logic [SAMPLE_W-1:0] POS_RAIL   = {1'b0, {(SAMPLE_W-1){1'b1}}};
  localparam logic [SAMPLE_W-1:0] NEG_RAIL   = {1'b1, {(SAMPLE_W-1){1'b0}}};

  assert_offset_store_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && !reg_addr) |=> off_hi == $past(reg_wdata[WORD_W-1:PAD_W]));

  assert_gain_store_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && reg_addr && !gain_clamp_hit) |=> gain_q == $past(reg_wdata[GAIN_W-1:0]));

  assert_gain_clamp_R3: assert property (@(posedge clk) disable iff (!rst_n)
    gain_clamp_hit |=> gain_q == GAIN_LIMIT);

  assert_gain_ceiling_R3: assert property (@(posedge clk) disable iff (!rst_n)
    gain_q <= GAIN_LIMIT);

  assert_rail_value_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ovf) |-> (out_word[WORD_W-1:PAD_W] == POS_RAIL ||
                                out_word[WORD_W-1:PAD_W] == NEG_RAIL));

  assert_sat_flag_R5: assert property (@(posedge clk) disable iff (!rst_n)
    sat_event |=> (out_valid && out_ovf));

  assert_stage1_R6: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> s1_valid);

  assert_stage2_R6: assert property (@(posedge clk) disable iff (!rst_n)
    s1_valid |=> s2_valid);

  assert_stage3_R6: assert property (@(posedge clk) disable iff (!rst_n)
    s2_valid |=> out_valid);

  assert_no_stray_out_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!in_valid && !s1_valid && !s2_valid) |=> ##1 (!s2_valid && !out_valid));

endmodule

bind sample_trim_path trim_checks #(
  .SAMPLE_W(SAMPLE_W), .WORD_W(WORD_W), .GAIN_W(GAIN_W),
  .GAIN_FRAC_W(GAIN_FRAC_W), .GAIN_CEIL(GAIN_CEIL)
) u_trim_checks (
  .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
  .reg_wdata(reg_wdata), .in_valid(in_valid), .s1_valid(s1_valid),
  .s2_valid(s2_valid), .sat_event(sat_event), .gain_clamp_hit(gain_clamp_hit),
  .out_valid(out_valid), .out_word(out_word), .out_ovf(out_ovf),
  .off_hi(off_hi), .gain_q(gain_q)
);

// File: tb/sample_trim_path_bench.sv
module sample_trim_path_bench;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 200000;

  typedef struct {
    logic [31:0] word;
    logic        ovf;
    int          due;
    string       tag;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic        reg_addr = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        in_valid = 1'b0;
  logic [23:0] in_sample = '0;
  logic        out_valid;
  logic [31:0] out_word;
  logic        out_ovf;

  int     n_checks = 0;
  int     n_fails  = 0;
  int     cyc      = 0;
  int     n_sent   = 0;
  int     n_seen   = 0;
  bit     finished = 1'b0;
  exp_t   sb[$];

  // Bench-side view of the trim registers, built from R2 and R3
  int     m_off  = 0;
  longint m_gain = 64'h0100_0000;

  sample_trim_path u_sample_trim_path (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .in_valid(in_valid),
    .in_sample(in_sample), .out_valid(out_valid), .out_word(out_word),
    .out_ovf(out_ovf)
  );

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  function automatic exp_t predict(input int s, input string tag);
    exp_t   e;
    longint p;
    longint r;
    p = longint'(s - m_off) * m_gain;
    r = (p + 64'sd8388608) >>> 24;
    e.ovf = 1'b0;
    if (r > 64'sd8388607)  begin r = 64'sd8388607;  e.ovf = 1'b1; end
    if (r < -64'sd8388608) begin r = -64'sd8388608; e.ovf = 1'b1; end
    e.word = {r[23:0], 8'h00};
    e.tag  = tag;
    e.due  = 0;
    return e;
  endfunction

  function automatic void model_write(input bit sel, input logic [31:0] w);
    longint g;
    if (!sel) begin
      m_off = int'($signed(w[31:8]));
    end else begin
      g = longint'(w[29:0]);
      if (g > 64'h2800_0000) g = 64'h2800_0000;
      m_gain = g;
    end
  endfunction

  task automatic send(input int s, input string tag);
    exp_t e;
    @(negedge clk);
    reg_we    = 1'b0;
    in_valid  = 1'b1;
    in_sample = s[23:0];
    e = predict(s, tag);
    e.due = cyc + 3;
    sb.push_back(e);
    n_sent++;
  endtask

  // Sample and register write presented on the same edge (R7)
  task automatic send_with_write(input int s, input bit sel, input logic [31:0] w, input string tag);
    exp_t e;
    @(negedge clk);
    in_valid  = 1'b1;
    in_sample = s[23:0];
    reg_we    = 1'b1;
    reg_addr  = sel;
    reg_wdata = w;
    e = predict(s, tag);
    e.due = cyc + 3;
    sb.push_back(e);
    n_sent++;
    model_write(sel, w);
    @(negedge clk);
    reg_we   = 1'b0;
    in_valid = 1'b0;
  endtask

  task automatic write_reg(input bit sel, input logic [31:0] w);
    @(negedge clk);
    in_valid  = 1'b0;
    reg_we    = 1'b1;
    reg_addr  = sel;
    reg_wdata = w;
    model_write(sel, w);
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic read_reg(input bit sel, input logic [31:0] exp, input string tag);
    @(negedge clk);
    in_valid = 1'b0;
    reg_we   = 1'b0;
    reg_addr = sel;
    #1;
    check(reg_rdata === exp, tag, longint'(reg_rdata), longint'(exp));
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid  = 1'b0;
      in_sample = 24'(i * 40503 + 17);
    end
  endtask

  // Scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && out_valid) begin
      n_seen++;
      if (sb.size() == 0) begin
        check(1'b0, "R9 unexpected output", longint'(out_word), 0);
      end else begin
        exp_t e;
        e = sb.pop_front();
        check(out_word === e.word, {e.tag, " word"}, longint'(out_word), longint'(e.word));
        check(out_ovf === e.ovf, {"R5 flag ", e.tag}, longint'(out_ovf), longint'(e.ovf));
        check(cyc == e.due, {"R6 latency ", e.tag}, longint'(cyc), longint'(e.due));
      end
    end
  end

  initial begin
    #(CLK_PERIOD * WATCHDOG);
    if (!finished) begin
      finished = 1'b1;
      n_checks++;
      n_fails++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
      $finish;
    end
  end

  initial begin
    int quiet_hits;
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state; R8 read select
    check(out_valid === 1'b0, "R1 out_valid after reset", longint'(out_valid), 0);
    read_reg(1'b0, 32'h0000_0000, "R1 offset reset / R8");
    read_reg(1'b1, 32'h0100_0000, "R1 gain reset / R8");

    // R4 and R6: unity gain, back-to-back samples including both rails
    send(0, "R4 zero");
    send(1234, "R4 positive");
    send(-5000, "R4 negative");
    send(8388607, "R4 top code");
    send(-8388608, "R4 bottom code");
    idle(5);

    // R2: low byte of the offset dropped
    write_reg(1'b0, 32'h0000_01AB);
    read_reg(1'b0, 32'h0000_0100, "R2 offset low byte");
    send(100, "R4 offset subtract");
    send(-8388608, "R5 negative rail via offset");
    idle(5);

    // R3: upper gain bits ignored
    write_reg(1'b1, 32'hC280_0000);
    read_reg(1'b1, 32'h0280_0000, "R3 gain top bits");
    send(101, "R4 gain 2.5");
    send(11, "R4 gain 2.5 small");
    send(-3, "R4 gain 2.5 negative");
    idle(5);

    // R3: ceiling clamp, R5 both rails
    write_reg(1'b1, 32'h3FFF_FFFF);
    read_reg(1'b1, 32'h2800_0000, "R3 gain clamp");
    send(300000, "R5 positive rail");
    send(-300000, "R5 negative rail");
    send(1000, "R4 gain 40");
    idle(5);
    write_reg(1'b1, 32'h2800_0000);
    read_reg(1'b1, 32'h2800_0000, "R3 gain at ceiling kept");

    // R4 rounding ties with gain 1.5 and zero offset
    write_reg(1'b0, 32'h0000_0000);
    write_reg(1'b1, 32'h0180_0000);
    read_reg(1'b0, 32'h0000_0000, "R2 offset cleared");
    send(1, "R4 tie up positive");
    send(-1, "R4 tie up negative");
    send(3, "R4 tie 4.5");
    send(-3, "R4 tie -4.5");
    idle(5);

    // R4 smallest gain step
    write_reg(1'b1, 32'h0000_0001);
    send(8388607, "R4 tiny gain");
    send(-8388608, "R4 tiny gain negative");
    idle(5);

    // R7: write on the accepting edge applies to later samples only
    write_reg(1'b1, 32'h0180_0000);
    send_with_write(10, 1'b1, 32'h0200_0000, "R7 old gain");
    send(10, "R7 new gain");
    send_with_write(10, 1'b0, 32'h0000_0500, "R7 old offset");
    send(10, "R7 new offset");
    read_reg(1'b1, 32'h0200_0000, "R7 gain after write / R8");
    idle(6);

    // R9: idle with toggling sample bus yields no output
    quiet_hits = 0;
    for (int i = 0; i < 12; i++) begin
      @(negedge clk);
      in_valid  = 1'b0;
      in_sample = 24'(i * 77777);
      if (out_valid) quiet_hits++;
    end
    check(quiet_hits == 0, "R9 idle outputs", longint'(quiet_hits), 0);

    idle(4);
    check(sb.size() == 0, "R6 results pending", longint'(sb.size()), 0);
    check(n_seen == n_sent, "R6 one result per sample", longint'(n_seen), longint'(n_sent));

    if (!finished) begin
      finished = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
      $finish;
    end
  end

endmodule